// File: doc/BRIEF.md
# Interrupt Vector Address Generator

This block holds the relocatable base of an exception vector table and turns an incoming exception number into the byte address where that handler's pointer is stored. Each table slot is one 32-bit word. Slot 0 holds the initial stack pointer, and the other slots follow it in ascending number order. The address is formed by a bitwise OR of the base and the slot's byte offset. There is no adder. A base that is not aligned to the power-of-two size of the whole table therefore makes some slots alias onto the wrong words. The block reports this condition on a dedicated flag.

Software reaches the base through a simple write strobe and a read-back bus. The lowest seven base bits do not exist. An exception request is one cycle of `exc_valid` with a number. The block answers one cycle later in one of two ways:
- a fetch strobe with the registered address, or
- an error pulse when the number is outside the table.

A three-state machine sequences the answer. The states are IDLE, ISSUE and REJECT. From any state, a valid in-range number moves it to ISSUE and a valid out-of-range number moves it to REJECT. A cycle with no request returns it to IDLE.

Top module: `vecaddr_gen`

## Requirements
- R1: With the base at zero, the fetch address equals four times the exception number. Number 0, the stack pointer slot, maps to address 0.
- R2: Base bits [6:0] always read as zero and ignore writes. Writing 0xFFFFFFFF reads back 0xFFFFFF80.
- R3: After reset the base reads zero, `fetch_stb`, `exc_err` and `base_misaligned` are low, and the machine is in IDLE.
- R4: The fetch address is base OR (number << 2). For base 0x8080 and number 61 it is 0x80F4. For base 0x8100 and number 89 it is 0x8164.
- R5: When `exc_valid` is high with an in-range number, `fetch_stb` is high in the following cycle with the address in `fetch_addr`. A single request gives a one-cycle pulse.
- R6: For the default 111 slots the required alignment is 0x200 bytes. `base_misaligned` is high exactly when base bit 7 or bit 8 is set.
- R7: A number of 111 or more raises `exc_err` for one cycle after the request, gives no strobe and leaves `fetch_addr` unchanged.
- R8: Back-to-back requests on consecutive cycles give back-to-back strobes, each with its own address. Without a request, `fetch_addr` holds its value.
- R9: A base write with no request pending produces neither `fetch_stb` nor `exc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Base register write strobe |
| cfg_wdata | input | 32 | Base register write data |
| cfg_rdata | output | 32 | Base register read value |
| exc_valid | input | 1 | Exception number valid |
| exc_num | input | 7 | Active exception number |
| fetch_addr | output | 32 | Registered handler pointer address |
| fetch_stb | output | 1 | One-cycle fetch request |
| exc_err | output | 1 | Out-of-range number reported |
| base_misaligned | output | 1 | Base not aligned to table size |

## Verification
The table-driven bench sets a series of bases. Some are aligned: zero, 0x8000 and 0x8200. Others are misaligned: 0x8080, 0x8100 and all ones. At each base it raises slots whose scaled offsets either set or avoid bits 7 and 8. The OR-versus-add cases separate a correct OR former from an adder, because an adder would give 0x8174 where 0x80F4 is expected. Pairs of slots at the same misaligned base show that aliasing depends on which bits overlap. The boundary numbers 110 and 111 separate the last valid slot from the first rejected one. Directed tests cover reset values, back-to-back requests and writes with no request.

// File: rtl/vecaddr_pkg.sv
package vecaddr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REJECT = 2'd2
    } vstate_e;
endpackage

// File: rtl/vbase_reg.sv
module vbase_reg #(
    parameter int ADDR_W   = 32,
    parameter int IMPL_LSB = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base
);
    // only the implemented upper bits are stored
    logic [ADDR_W-1:IMPL_LSB] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (wr_en) begin
            hi_q <= wdata[ADDR_W-1:IMPL_LSB];
        end
    end

    assign base = {hi_q, {IMPL_LSB{1'b0}}};
endmodule

// File: rtl/valign_chk.sv
module valign_chk #(
    parameter int ADDR_W     = 32,
    parameter int IMPL_LSB   = 7,
    parameter int ALIGN_BITS = 9
) (
    input  logic [ADDR_W-1:0] base,
    output logic              misaligned
);
    generate
        if (ALIGN_BITS > IMPL_LSB) begin : g_check
            assign misaligned = |base[ALIGN_BITS-1:IMPL_LSB];
        end else begin : g_none
            logic unused_base;
            assign unused_base = ^base;
            assign misaligned  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/vaddr_form.sv
module vaddr_form #(
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 111,
    parameter int NUM_W       = 7
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NUM_W-1:0]  num,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam int SLOT_SHIFT = 2;  // one 32-bit word per slot

    logic [ADDR_W-1:0] offset;

    assign offset   = ADDR_W'(num) << SLOT_SHIFT;
    assign addr     = base | offset;
    assign in_range = (ADDR_W'(num) < ADDR_W'(NUM_ENTRIES));
endmodule

// File: rtl/vecaddr_gen.sv
module vecaddr_gen
    import vecaddr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IMPL_LSB    = 7,
    parameter int NUM_ENTRIES = 111,
    parameter int NUM_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              exc_valid,
    input  logic [NUM_W-1:0]  exc_num,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_stb,
    output logic              exc_err,
    output logic              base_misaligned
);
    // table bytes rounded up to a power of two
    localparam int ALIGN_BITS = $clog2(NUM_ENTRIES * 4);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] formed;
    logic              in_range;
    logic [ADDR_W-1:0] addr_q;
    vstate_e           state_q, state_d;

    vbase_reg #(.ADDR_W(ADDR_W), .IMPL_LSB(IMPL_LSB)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .base  (base)
    );

    valign_chk #(.ADDR_W(ADDR_W), .IMPL_LSB(IMPL_LSB), .ALIGN_BITS(ALIGN_BITS)) u_align (
        .base       (base),
        .misaligned (base_misaligned)
    );

    vaddr_form #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .NUM_W(NUM_W)) u_form (
        .base     (base),
        .num      (exc_num),
        .addr     (formed),
        .in_range (in_range)
    );

    // next-state decision
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_REJECT: begin
                if (exc_valid) begin
                    state_d = in_range ? ST_ISSUE : ST_REJECT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // address captured on an accepted request only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (exc_valid && in_range) begin
            addr_q <= formed;
        end
    end

    // output decode
    always_comb begin
        fetch_stb = 1'b0;
        exc_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  fetch_stb = 1'b1;
            ST_REJECT: exc_err   = 1'b1;
            default:   ;
        endcase
    end

    assign fetch_addr = addr_q;
    assign cfg_rdata  = base;
endmodule

// File: rtl/vecaddr_gen_chk.sv
module vecaddr_gen_chk #(
    parameter int ADDR_W      = 32,
    parameter int IMPL_LSB    = 7,
    parameter int NUM_ENTRIES = 111,
    parameter int NUM_W       = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              exc_valid,
    input logic [NUM_W-1:0]  exc_num,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_stb,
    input logic              exc_err,
    input logic              base_misaligned
);
    localparam int ALIGN_BITS = $clog2(NUM_ENTRIES * 4);
    localparam logic [ADDR_W-1:0] KEEP  = ~((ADDR_W'(1) << IMPL_LSB) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] AMASK = ((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1)) & KEEP;

    AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & KEEP)); // R2

    AST_RESET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == '0 && !fetch_stb && !exc_err)); // R3

    AST_OR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && ADDR_W'(exc_num) < ADDR_W'(NUM_ENTRIES)) |=>
        (fetch_stb && fetch_addr == ($past(cfg_rdata) | (ADDR_W'($past(exc_num)) << 2)))); // R4

    AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> ($past(exc_valid) && ADDR_W'($past(exc_num)) < ADDR_W'(NUM_ENTRIES))); // R5

    AST_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        base_misaligned == ((cfg_rdata & AMASK) != '0)); // R6

    AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && ADDR_W'(exc_num) >= ADDR_W'(NUM_ENTRIES)) |=>
        (exc_err && !fetch_stb && $stable(fetch_addr))); // R7

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_stb, exc_err})); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> $stable(fetch_addr)); // R8

    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> (!fetch_stb && !exc_err)); // R9
endmodule

bind vecaddr_gen vecaddr_gen_chk #(
    .ADDR_W(ADDR_W), .IMPL_LSB(IMPL_LSB), .NUM_ENTRIES(NUM_ENTRIES), .NUM_W(NUM_W)
) u_chk (.*);

// File: tb/vecaddr_gen_test.sv
module vecaddr_gen_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] base;
        logic [6:0]  num;
        logic [31:0] addr;
        logic        err;
        logic        mis;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{32'h0000_0000, 7'd0,   32'h0000_0000, 1'b0, 1'b0},
        '{32'h0000_0000, 7'd89,  32'h0000_0164, 1'b0, 1'b0},
        '{32'h0000_8000, 7'd61,  32'h0000_80F4, 1'b0, 1'b0},
        '{32'h0000_8000, 7'd89,  32'h0000_8164, 1'b0, 1'b0},
        '{32'h0000_8080, 7'd89,  32'h0000_81E4, 1'b0, 1'b1},
        '{32'h0000_8080, 7'd61,  32'h0000_80F4, 1'b0, 1'b1},
        '{32'h0000_8100, 7'd89,  32'h0000_8164, 1'b0, 1'b1},
        '{32'h0000_8100, 7'd61,  32'h0000_81F4, 1'b0, 1'b1},
        '{32'h0000_8200, 7'd110, 32'h0000_83B8, 1'b0, 1'b0},
        '{32'h0000_8200, 7'd111, 32'h0000_0000, 1'b1, 1'b0},
        '{32'hFFFF_FFFF, 7'd1,   32'hFFFF_FF84, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        exc_valid = 1'b0;
    logic [6:0]  exc_num = '0;
    logic [31:0] fetch_addr;
    logic        fetch_stb;
    logic        exc_err;
    logic        base_misaligned;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vecaddr_gen uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr          (cfg_wr),
        .cfg_wdata       (cfg_wdata),
        .cfg_rdata       (cfg_rdata),
        .exc_valid       (exc_valid),
        .exc_num         (exc_num),
        .fetch_addr      (fetch_addr),
        .fetch_stb       (fetch_stb),
        .exc_err         (exc_err),
        .base_misaligned (base_misaligned)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        // R3: reset values
        chk("R3 base", cfg_rdata, 32'h0);
        chk("R3 stb", {31'b0, fetch_stb}, 32'h0);
        chk("R3 err", {31'b0, exc_err}, 32'h0);
        chk("R3 mis", {31'b0, base_misaligned}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 idle stb", {31'b0, fetch_stb}, 32'h0);

        // table walk: R1 R2 R4 R5 R6 R7
        for (int i = 0; i < 11; i++) begin
            write_base(VECS[i].base);
            chk("R2 readback", cfg_rdata, VECS[i].base & 32'hFFFF_FF80);
            chk("R6 misaligned", {31'b0, base_misaligned}, {31'b0, VECS[i].mis});
            chk("R9 no stb on write", {31'b0, fetch_stb | exc_err}, 32'h0);
            prev = fetch_addr;
            exc_valid = 1'b1;
            exc_num   = VECS[i].num;
            @(negedge clk);
            exc_valid = 1'b0;
            chk("R5/R7 stb", {31'b0, fetch_stb}, {31'b0, ~VECS[i].err});
            chk("R7 err", {31'b0, exc_err}, {31'b0, VECS[i].err});
            if (VECS[i].err) chk("R7 addr kept", fetch_addr, prev);
            else             chk("R1/R4 addr", fetch_addr, VECS[i].addr);
            @(negedge clk);
            chk("R5 one-cycle stb", {31'b0, fetch_stb | exc_err}, 32'h0);
        end

        // R2: all-ones readback
        write_base(32'hFFFF_FFFF);
        chk("R2 all ones", cfg_rdata, 32'hFFFF_FF80);

        // R8: back-to-back requests at an aligned base
        write_base(32'h0001_0000);
        exc_valid = 1'b1;
        exc_num   = 7'd3;
        @(negedge clk);
        chk("R8 first stb", {31'b0, fetch_stb}, 32'h1);
        chk("R8 first addr", fetch_addr, 32'h0001_000C);
        exc_num = 7'd4;
        @(negedge clk);
        exc_valid = 1'b0;
        chk("R8 second stb", {31'b0, fetch_stb}, 32'h1);
        chk("R8 second addr", fetch_addr, 32'h0001_0010);
        repeat (2) @(negedge clk);
        chk("R8 addr held", fetch_addr, 32'h0001_0010);
        chk("R8 stb low", {31'b0, fetch_stb}, 32'h0);

        // R9: base write alone changes no fetch output
        write_base(32'h0000_4000);
        @(negedge clk);
        chk("R9 quiet", {30'b0, fetch_stb, exc_err}, 32'h0);
        chk("R9 addr kept", fetch_addr, 32'h0001_0010);

        summary();
    end
endmodule